// File: doc/BRIEF.md
# Serial LED Shift-Out Controller

This block drives a row of up to 24 output bits, typically indicator LEDs, through an external chain of serial-in, parallel-out shift registers. It needs only three pins: a shift clock, a serial data line and a store strobe. The store strobe copies the shifted bits onto the chain's parallel outputs. Software programs the block through a small word-addressed register port. It writes the wanted pattern into a data register and then either requests a single transfer or lets the block refresh the chain on its own at one of four low rates.

Each transfer captures the pattern, the group enables and the shift edge when it starts. It sends only the bits of enabled groups, most significant first, and then raises the store strobe for one shift-clock period. Two hardware status lines can stand in for pattern bits 0 and 1, so that a link or activity indicator needs no software involvement. A request that arrives while a transfer is running is held until that transfer completes, and is then served.

Top module: `led_chain_ctrl`

## Requirements
- R1: After reset every register reads 0, and `sh_clk`, `sh_data` and `sh_store` are low.
- R2: Registers sit at word index 0 (control A), 1 (control B), 2 (pattern), 3 (spare word) and 4 (auxiliary word). The pattern, spare and auxiliary words read back exactly what was written. Control B reads back update source in bits 31:30, rate code in 26:23 and group enables in 1:0, with all other bits 0. Control A bit 30 is read-only.
- R3: Writing control A with bit 31 set starts one transfer. After the last bit, `sh_store` is high for exactly 2*SCK_HALF clock cycles, and `sh_clk` stays at its idle level during that time.
- R4: Control A bit 26 = 0 makes `sh_clk` idle low so that the chain samples on the rising edge. A value of 1 makes it idle high so that the chain samples on the falling edge. `sh_data` changes only while `sh_clk` is at its idle level.
- R5: Control B bit 0 enables pattern bits 15:0 and bit 1 enables bits 23:16. Only enabled bits are sent, highest index first. With no group enabled, a transfer sends no bits and still pulses `sh_store`.
- R6: Control A bit 24 replaces pattern bit 0 with `hw_led[0]`, and bit 25 replaces pattern bit 1 with `hw_led[1]`.
- R7: Control A bit 30 reads 1 from the start of a transfer until the store strobe ends, and 0 otherwise.
- R8: Control A bit 31 reads 1 while a request waits and drops to 0 when its transfer starts. A request written during a transfer is served right after that transfer completes.
- R9: A transfer uses the pattern, enables, override selects and edge that held at its start. Writes made during the transfer affect only later transfers.
- R10: With control B bit 31 set, a transfer starts every CLK_HZ/F cycles, where F is 2, 4, 8 or 10 for rate codes 0, 1, 2 and 3. Codes above 3 behave as 10. With bit 31 clear, no automatic transfers occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| hw_led | input | 2 | Hardware status that can replace pattern bits 1:0 |
| sh_clk | output | 1 | Shift clock to the external chain |
| sh_data | output | 1 | Serial data to the external chain |
| sh_store | output | 1 | Store strobe to the external chain |

## Verification
The bench models the external chain as a stub that samples `sh_data` on the programmed active edge and latches on the rising store strobe. It then compares the latched word and bit count with a bench function.

Directed patterns isolate single behaviours. Group 0 alone, both groups and no group show that the enable mask and the most-significant-first ordering hold. Falling-edge mode shows the inverted idle level. An override with status bits opposite to the pattern shows where the override comes from.

Random patterns, groups, overrides and edges then mix these settings. A pattern rewritten during a transfer, followed by a second request, separates the captured pattern from the live one and checks the deferred request. Store-to-store intervals at several rate codes, including an out-of-range code, tell the prescaler limits apart.

// File: rtl/led_chain_pkg.sv
// Package: register indices and field positions for the serial LED controller.
// Assumes a 32-bit register port addressed by word index.
package led_chain_pkg;
    localparam int REG_DW      = 32;
    localparam int REG_AW      = 3;
    // Word indices of the registers
    localparam logic [REG_AW-1:0] IDX_CTRL_A = 3'd0;
    localparam logic [REG_AW-1:0] IDX_CTRL_B = 3'd1;
    localparam logic [REG_AW-1:0] IDX_PAT    = 3'd2;
    localparam logic [REG_AW-1:0] IDX_SPARE  = 3'd3;
    localparam logic [REG_AW-1:0] IDX_AUX    = 3'd4;
    // Control A fields
    localparam int CA_REQ      = 31;
    localparam int CA_BUSY     = 30;
    localparam int CA_EDGE     = 26;
    localparam int CA_OVR_LO   = 24;
    // Control B fields
    localparam int CB_SRC_LO   = 30;
    localparam int CB_RATE_LO  = 23;
    localparam int RATE_W      = 4;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_SHIFT = 2'd1,
        ENG_STORE = 2'd2
    } eng_state_e;
endpackage

// File: rtl/led_chain_regs.sv
// Module: register file of the serial LED controller.
// Holds configuration, pattern and the pending update request.
// Assumes NBITS <= 32 and NGRP <= 23; reads are combinational.
module led_chain_regs
    import led_chain_pkg::*;
#(
    parameter int NBITS = 24,
    parameter int NGRP  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [REG_DW-1:0] bus_wdata,
    output logic [REG_DW-1:0] bus_rdata,
    input  logic              eng_busy,
    input  logic              eng_start,
    output logic              cfg_edge_fall,
    output logic [1:0]        cfg_ovr,
    output logic              cfg_auto,
    output logic [RATE_W-1:0] cfg_rate,
    output logic [NGRP-1:0]   cfg_grp,
    output logic [NBITS-1:0]  pattern,
    output logic              req_pend,
    output logic              req_set
);
    logic              wr;
    logic              edge_q;
    logic [1:0]        ovr_q;
    logic [1:0]        src_q;
    logic [RATE_W-1:0] rate_q;
    logic [NGRP-1:0]   grp_q;
    logic [REG_DW-1:0] pat_q;
    logic [REG_DW-1:0] spare_q;
    logic [REG_DW-1:0] aux_q;
    logic              req_q;

    assign wr      = bus_sel & bus_we;
    assign req_set = wr && (bus_addr == IDX_CTRL_A) && bus_wdata[CA_REQ];

    // Configuration and data storage, written from the bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_q  <= 1'b0;
            ovr_q   <= '0;
            src_q   <= '0;
            rate_q  <= '0;
            grp_q   <= '0;
            pat_q   <= '0;
            spare_q <= '0;
            aux_q   <= '0;
        end else if (wr) begin
            case (bus_addr)
                IDX_CTRL_A: begin
                    edge_q <= bus_wdata[CA_EDGE];
                    ovr_q  <= bus_wdata[CA_OVR_LO +: 2];
                end
                IDX_CTRL_B: begin
                    src_q  <= bus_wdata[CB_SRC_LO +: 2];
                    rate_q <= bus_wdata[CB_RATE_LO +: RATE_W];
                    grp_q  <= bus_wdata[NGRP-1:0];
                end
                IDX_PAT:   pat_q   <= bus_wdata;
                IDX_SPARE: spare_q <= bus_wdata;
                IDX_AUX:   aux_q   <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Pending request: a new write wins over the clear from a starting transfer
    always_ff @(posedge clk) begin
        if (!rst_n)
            req_q <= 1'b0;
        else if (req_set)
            req_q <= 1'b1;
        else if (eng_start)
            req_q <= 1'b0;
    end

    // Read multiplexer
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            IDX_CTRL_A: begin
                bus_rdata[CA_REQ]          = req_q;
                bus_rdata[CA_BUSY]         = eng_busy;
                bus_rdata[CA_EDGE]         = edge_q;
                bus_rdata[CA_OVR_LO +: 2]  = ovr_q;
            end
            IDX_CTRL_B: begin
                bus_rdata[CB_SRC_LO +: 2]       = src_q;
                bus_rdata[CB_RATE_LO +: RATE_W] = rate_q;
                bus_rdata[NGRP-1:0]             = grp_q;
            end
            IDX_PAT:   bus_rdata = pat_q;
            IDX_SPARE: bus_rdata = spare_q;
            IDX_AUX:   bus_rdata = aux_q;
            default:   bus_rdata = '0;
        endcase
    end

    assign cfg_edge_fall = edge_q;
    assign cfg_ovr       = ovr_q;
    assign cfg_auto      = src_q[1];
    assign cfg_rate      = rate_q;
    assign cfg_grp       = grp_q;
    assign pattern       = pat_q[NBITS-1:0];
    assign req_pend      = req_q;
endmodule

// File: rtl/led_chain_rate.sv
// Module: refresh prescaler. Emits a one-cycle tick every CLK_HZ/F cycles.
// Assumes CLK_HZ >= 20 so that every period is at least 2 cycles; idle when disabled.
module led_chain_rate
    import led_chain_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam int P2  = CLK_HZ / 2;
    localparam int P4  = CLK_HZ / 4;
    localparam int P8  = CLK_HZ / 8;
    localparam int P10 = CLK_HZ / 10;
    localparam int CW  = $clog2(P2 + 1);

    logic [CW-1:0] lim;
    logic [CW-1:0] cnt;
    logic          wrap;

    // Period select; codes above 3 use the fastest rate
    always_comb begin
        case (rate)
            4'd0:    lim = CW'(P2);
            4'd1:    lim = CW'(P4);
            4'd2:    lim = CW'(P8);
            default: lim = CW'(P10);
        endcase
    end

    assign wrap = (cnt >= lim - 1'b1);

    // Cycle counter and registered tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else begin
            tick <= en && wrap;
            cnt  <= (en && !wrap) ? cnt + 1'b1 : '0;
        end
    end
endmodule

// File: rtl/led_chain_engine.sv
// Module: shift engine. Captures the enabled bits on start, sends them MSB first,
// then raises the store strobe for one shift-clock period.
// Assumes pattern, enable mask and edge stay meaningful only at the start cycle.
module led_chain_engine
    import led_chain_pkg::*;
#(
    parameter int NBITS    = 24,
    parameter int SCK_HALF = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NBITS-1:0] pattern,
    input  logic [NBITS-1:0] enmask,
    input  logic             edge_cfg,
    output logic             start,
    output logic             busy,
    output logic             idle_lvl,
    output logic             sh_clk,
    output logic             sh_data,
    output logic             sh_store
);
    localparam int CNT_W = $clog2(NBITS + 1);
    localparam int DIV_W = $clog2(SCK_HALF + 1);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCK_HALF - 1);

    eng_state_e        state;
    logic [NBITS-1:0]  sreg;
    logic [CNT_W-1:0]  left;
    logic [DIV_W-1:0]  dcnt;
    logic              half;
    logic              run_edge;
    logic [NBITS-1:0]  pk;
    logic [CNT_W-1:0]  pk_cnt;
    logic              half_end;

    // Pack enabled bits left-aligned, highest index first
    always_comb begin
        int n;
        pk = '0;
        n  = 0;
        for (int i = NBITS - 1; i >= 0; i--) begin
            if (enmask[i]) begin
                pk[NBITS-1-n] = pattern[i];
                n = n + 1;
            end
        end
        pk_cnt = CNT_W'(n);
    end

    assign start    = (state == ENG_IDLE) && go;
    assign half_end = (dcnt == DIV_LAST);

    // Sequencer: idle, shifting bit halves, store period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ENG_IDLE;
            sreg     <= '0;
            left     <= '0;
            dcnt     <= '0;
            half     <= 1'b0;
            run_edge <= 1'b0;
        end else begin
            case (state)
                ENG_IDLE: begin
                    run_edge <= edge_cfg;
                    if (go) begin
                        sreg  <= pk;
                        left  <= pk_cnt;
                        dcnt  <= '0;
                        half  <= 1'b0;
                        state <= (pk_cnt == '0) ? ENG_STORE : ENG_SHIFT;
                    end
                end
                ENG_SHIFT: begin
                    if (half_end) begin
                        dcnt <= '0;
                        if (!half) begin
                            half <= 1'b1;
                        end else begin
                            half <= 1'b0;
                            sreg <= sreg << 1;
                            left <= left - 1'b1;
                            if (left == CNT_W'(1))
                                state <= ENG_STORE;
                        end
                    end else begin
                        dcnt <= dcnt + 1'b1;
                    end
                end
                ENG_STORE: begin
                    if (half_end) begin
                        dcnt <= '0;
                        half <= ~half;
                        if (half)
                            state <= ENG_IDLE;
                    end else begin
                        dcnt <= dcnt + 1'b1;
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    assign busy     = (state != ENG_IDLE);
    assign idle_lvl = run_edge;
    assign sh_clk   = run_edge ^ ((state == ENG_SHIFT) && half);
    assign sh_data  = (state == ENG_SHIFT) && sreg[NBITS-1];
    assign sh_store = (state == ENG_STORE);
endmodule

// File: rtl/led_chain_ctrl.sv
// Module: top of the serial LED shift-out controller.
// Joins register file, refresh prescaler and shift engine; applies group
// enables and the hardware override of bits 1:0. Assumes NBITS >= 2.
module led_chain_ctrl
    import led_chain_pkg::*;
#(
    parameter int CLK_HZ   = 50_000_000,
    parameter int NBITS    = 24,
    parameter int GRP_W    = 16,
    parameter int SCK_HALF = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [2:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [1:0]        hw_led,
    output logic              sh_clk,
    output logic              sh_data,
    output logic              sh_store
);
    localparam int NGRP = (NBITS + GRP_W - 1) / GRP_W;

    logic              cfg_edge_fall;
    logic [1:0]        cfg_ovr;
    logic              cfg_auto;
    logic [RATE_W-1:0] cfg_rate;
    logic [NGRP-1:0]   cfg_grp;
    logic [NBITS-1:0]  pattern;
    logic [NBITS-1:0]  eff;
    logic [NBITS-1:0]  enmask;
    logic              req_pend;
    logic              req_set;
    logic              tick;
    logic              go;
    logic              eng_start;
    logic              eng_busy;
    logic              idle_lvl;

    led_chain_regs #(.NBITS(NBITS), .NGRP(NGRP)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_sel       (bus_sel),
        .bus_we        (bus_we),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .eng_busy      (eng_busy),
        .eng_start     (eng_start),
        .cfg_edge_fall (cfg_edge_fall),
        .cfg_ovr       (cfg_ovr),
        .cfg_auto      (cfg_auto),
        .cfg_rate      (cfg_rate),
        .cfg_grp       (cfg_grp),
        .pattern       (pattern),
        .req_pend      (req_pend),
        .req_set       (req_set)
    );

    led_chain_rate #(.CLK_HZ(CLK_HZ)) u_rate (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cfg_auto),
        .rate  (cfg_rate),
        .tick  (tick)
    );

    // Per-bit enable from its group, and status override of the two low bits
    for (genvar gi = 0; gi < NBITS; gi++) begin : g_bit
        assign enmask[gi] = cfg_grp[gi / GRP_W];
        if (gi < 2) begin : g_ovr
            assign eff[gi] = cfg_ovr[gi] ? hw_led[gi] : pattern[gi];
        end else begin : g_pass
            assign eff[gi] = pattern[gi];
        end
    end

    assign go = req_pend | tick;

    led_chain_engine #(.NBITS(NBITS), .SCK_HALF(SCK_HALF)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .pattern  (eff),
        .enmask   (enmask),
        .edge_cfg (cfg_edge_fall),
        .start    (eng_start),
        .busy     (eng_busy),
        .idle_lvl (idle_lvl),
        .sh_clk   (sh_clk),
        .sh_data  (sh_data),
        .sh_store (sh_store)
    );
endmodule

// File: rtl/led_chain_ctrl_chk.sv
// Module: property checker for led_chain_ctrl, attached with bind below.
// Assumes synchronous active-low reset; store length is counted, not unrolled.
module led_chain_ctrl_chk #(
    parameter int SCK_HALF = 8
) (
    input logic clk,
    input logic rst_n,
    input logic sh_clk,
    input logic sh_data,
    input logic sh_store,
    input logic busy,
    input logic start,
    input logic req_pend,
    input logic req_set,
    input logic tick,
    input logic auto_en,
    input logic idle_lvl
);
    localparam int LW = $clog2(2 * SCK_HALF + 2);
    logic [LW-1:0] st_len;

    // Count cycles the store strobe has been high
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_len <= '0;
        else
            st_len <= sh_store ? st_len + 1'b1 : '0;
    end

    AST_STORE_CLK_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_store && $past(sh_store)) |-> $stable(sh_clk));                      // R3
    AST_STORE_LEN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        sh_store |-> (st_len < LW'(2 * SCK_HALF)));                             // R3
    AST_STORE_LEN_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sh_store) |-> (st_len == LW'(2 * SCK_HALF)));                     // R3
    AST_DATA_AT_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sh_data) |-> (sh_clk == idle_lvl));                            // R4
    AST_BUSY_COVERS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        sh_store |-> busy);                                                     // R7
    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);                                                       // R8
    AST_REQ_DROPS_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !req_set) |=> !req_pend);                                     // R8
    AST_TICK_NEEDS_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(auto_en));                                               // R10
endmodule

bind led_chain_ctrl led_chain_ctrl_chk #(.SCK_HALF(SCK_HALF)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sh_clk   (sh_clk),
    .sh_data  (sh_data),
    .sh_store (sh_store),
    .busy     (eng_busy),
    .start    (eng_start),
    .req_pend (req_pend),
    .req_set  (req_set),
    .tick     (tick),
    .auto_en  (cfg_auto),
    .idle_lvl (idle_lvl)
);

// File: tb/tb_led_chain_ctrl.sv
// Bench: chain stub on the three pins, directed and seeded random transfers.
module tb_led_chain_ctrl;
    localparam int CLK_HZ   = 8000;
    localparam int NBITS    = 24;
    localparam int SCK_HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  hw_led = '0;
    logic        sh_clk, sh_data, sh_store;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // Chain stub state
    logic        edge_mode = 1'b0;
    logic        prev_sck = 1'b0;
    logic        prev_st = 1'b0;
    logic [23:0] chain = '0;
    int          nbits = 0;
    logic [23:0] lat_chain = '0;
    int          lat_n = 0;
    int          st_cnt = 0;
    int          st_w = 0;
    int          last_w = 0;
    int          st_time = 0;

    led_chain_ctrl #(.CLK_HZ(CLK_HZ), .NBITS(NBITS), .GRP_W(16), .SCK_HALF(SCK_HALF)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hw_led(hw_led), .sh_clk(sh_clk), .sh_data(sh_data), .sh_store(sh_store)
    );

    always #2 clk = ~clk;   // 250 MHz

    always @(posedge clk) cyc <= cyc + 1;

    // External chain model, sampled away from the active clock edge
    always @(negedge clk) begin
        if ((!edge_mode && !prev_sck && sh_clk) || (edge_mode && prev_sck && !sh_clk)) begin
            chain <= {chain[22:0], sh_data};
            nbits <= nbits + 1;
        end
        if (sh_store && !prev_st) begin
            lat_chain <= chain;
            lat_n     <= nbits;
            st_cnt    <= st_cnt + 1;
            st_time   <= cyc;
        end
        if (sh_store) st_w <= st_w + 1;
        if (!sh_store && prev_st) begin
            last_w <= st_w;
            st_w   <= 0;
            chain  <= '0;
            nbits  <= 0;
        end
        prev_sck <= sh_clk;
        prev_st  <= sh_store;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    function automatic logic [23:0] eff_pat(input logic [23:0] d, input logic [1:0] ov, input logic [1:0] hw);
        logic [23:0] e = d;
        if (ov[0]) e[0] = hw[0];
        if (ov[1]) e[1] = hw[1];
        return e;
    endfunction

    function automatic logic [23:0] exp_chain(input logic [23:0] e, input logic [1:0] g);
        logic [23:0] r = '0;
        for (int i = 23; i >= 0; i--)
            if (g[i / 16]) r = {r[22:0], e[i]};
        return r;
    endfunction

    function automatic int exp_cnt(input logic [1:0] g);
        return (g[0] ? 16 : 0) + (g[1] ? 8 : 0);
    endfunction

    function automatic logic [31:0] ctla(input logic req, input logic edg, input logic [1:0] ov);
        logic [31:0] v = '0;
        v[31] = req; v[26] = edg; v[25:24] = ov;
        return v;
    endfunction

    function automatic logic [31:0] ctlb(input logic [1:0] src, input logic [3:0] rate, input logic [1:0] g);
        logic [31:0] v = '0;
        v[31:30] = src; v[26:23] = rate; v[1:0] = g;
        return v;
    endfunction

    task automatic wait_store(input string req);
        int c0 = st_cnt;
        int t = 0;
        while (st_cnt == c0 && t < 10000) begin
            @(negedge clk);
            t++;
        end
        if (st_cnt == c0) chk(req, 32'h0, 32'h1);   // timeout, no store seen
    endtask

    task automatic settle();
        repeat (2 * SCK_HALF + 3) @(negedge clk);
    endtask

    // One software-triggered transfer, checked against the chain stub
    task automatic run_one(input logic [23:0] d, input logic [1:0] g, input logic [1:0] ov,
                           input logic [1:0] hw, input logic edg, input string req);
        logic [23:0] e;
        hw_led = hw;
        edge_mode = edg;
        wr(3'd1, ctlb(2'b00, 4'd0, g));
        wr(3'd2, {8'h0, d});
        wr(3'd0, ctla(1'b0, edg, ov));
        wr(3'd0, ctla(1'b1, edg, ov));
        wait_store(req);
        settle();
        e = eff_pat(d, ov, hw);
        chk(req, {8'h0, lat_chain}, {8'h0, exp_chain(e, g)});
        chk(req, lat_n, exp_cnt(g));
        chk("R3 store width", last_w, 2 * SCK_HALF);
        chk("R4 idle level", {31'h0, sh_clk}, {31'h0, edg});
    endtask

    initial begin
        logic [31:0] r;
        int t1;
        int c0;
        void'($urandom(32'h1ed5));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), r);
            chk("R1 reset register", r, 32'h0);
        end
        chk("R1 pins", {29'h0, sh_clk, sh_data, sh_store}, 32'h0);

        // R2: register readback, busy bit read-only
        begin
            logic [31:0] v1 = $urandom;
            logic [31:0] v2 = $urandom;
            logic [31:0] v3 = $urandom;
            wr(3'd3, v1); rd(3'd3, r); chk("R2 spare word", r, v1);
            wr(3'd4, v2); rd(3'd4, r); chk("R2 aux word", r, v2);
            wr(3'd2, v3); rd(3'd2, r); chk("R2 pattern word", r, v3);
        end
        wr(3'd1, 32'h7FFF_FFFF); rd(3'd1, r);
        chk("R2 control B fields", r, ctlb(2'b01, 4'hF, 2'b11));
        wr(3'd1, 32'h0);
        wr(3'd0, 32'h4000_0000); rd(3'd0, r);
        chk("R2 busy read-only", r, 32'h0);

        // Directed transfers
        run_one(24'hA5C3_3C, 2'b01, 2'b00, 2'b00, 1'b0, "R3 R5 group0 only");
        run_one(24'h81_F00F, 2'b11, 2'b00, 2'b00, 1'b0, "R5 both groups");
        run_one(24'hFF_FFFF, 2'b10, 2'b00, 2'b00, 1'b0, "R5 group1 only");
        run_one(24'h12_3456, 2'b00, 2'b00, 2'b00, 1'b0, "R5 no group");
        run_one(24'h96_5A69, 2'b11, 2'b00, 2'b00, 1'b1, "R4 falling edge");
        run_one(24'h00_0001, 2'b01, 2'b11, 2'b10, 1'b0, "R6 override both");
        run_one(24'h00_0002, 2'b11, 2'b01, 2'b01, 1'b1, "R6 override bit0");

        // Seeded random transfers
        for (int k = 0; k < 10; k++) begin
            logic [23:0] d = 24'($urandom);
            logic [1:0]  g = 2'($urandom);
            logic [1:0]  o = 2'($urandom);
            logic [1:0]  h = 2'($urandom);
            logic        e = 1'($urandom);
            run_one(d, g, o, h, e, "R5 R6 R4 random");
        end

        // R7: busy during a transfer, clear after
        edge_mode = 1'b0;
        hw_led = 2'b00;
        wr(3'd0, ctla(1'b0, 1'b0, 2'b00));
        wr(3'd1, ctlb(2'b00, 4'd0, 2'b11));
        wr(3'd2, 32'h00AB_CDEF);
        wr(3'd0, ctla(1'b1, 1'b0, 2'b00));
        repeat (8) @(negedge clk);
        rd(3'd0, r); chk("R7 busy while shifting", {31'h0, r[30]}, 32'h1);
        wait_store("R7 store");
        settle();
        rd(3'd0, r); chk("R7 busy cleared", {31'h0, r[30]}, 32'h0);

        // R8, R9: deferred request and captured pattern
        wr(3'd2, 32'h0012_3456);
        wr(3'd0, ctla(1'b1, 1'b0, 2'b00));
        repeat (6) @(negedge clk);
        wr(3'd2, 32'h00FE_DCBA);
        wr(3'd0, ctla(1'b1, 1'b0, 2'b00));
        rd(3'd0, r); chk("R8 request pending", {31'h0, r[31]}, 32'h1);
        wait_store("R9 first store");
        chk("R9 captured pattern", {8'h0, lat_chain}, {8'h0, exp_chain(24'h12_3456, 2'b11)});
        settle();
        wait_store("R8 deferred store");
        chk("R8 deferred pattern", {8'h0, lat_chain}, {8'h0, exp_chain(24'hFE_DCBA, 2'b11)});
        settle();
        rd(3'd0, r); chk("R8 request cleared", {31'h0, r[31]}, 32'h0);

        // R10: periodic refresh intervals
        wr(3'd1, ctlb(2'b10, 4'd3, 2'b01));
        wait_store("R10 auto start"); t1 = st_time;
        wait_store("R10 code3");
        chk("R10 code 3 interval", st_time - t1, CLK_HZ / 10);
        wr(3'd1, ctlb(2'b10, 4'd2, 2'b01));
        wait_store("R10 code2 a"); t1 = st_time;
        wait_store("R10 code2 b");
        chk("R10 code 2 interval", st_time - t1, CLK_HZ / 8);
        wr(3'd1, ctlb(2'b11, 4'd0, 2'b01));
        wait_store("R10 code0 a"); t1 = st_time;
        wait_store("R10 code0 b");
        chk("R10 code 0 interval", st_time - t1, CLK_HZ / 2);
        wr(3'd1, ctlb(2'b10, 4'd9, 2'b01));
        wait_store("R10 code9 a"); t1 = st_time;
        wait_store("R10 code9 b");
        chk("R10 code 9 interval", st_time - t1, CLK_HZ / 10);
        wr(3'd1, ctlb(2'b01, 4'd3, 2'b01));
        settle();
        c0 = st_cnt;
        repeat (CLK_HZ / 2 + 100) @(negedge clk);
        chk("R10 no auto refresh", st_cnt - c0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule